// File: doc/BRIEF.md
# One-shot countdown event timer

This block is a small register-mapped countdown timer for raising a single timed interrupt. Software first sets the clock-enable bit in the control word. It then writes a tick count into the count register, and that write starts the countdown. The counter steps down once for each cycle on which the external tick-enable input is high. When it reaches zero it latches a pending event and stops. It stays stopped until the count register is written again.

The single interrupt output is the pending event gated by the interrupt-enable and clock-enable bits. Software can drop the pending event and mask the interrupt in one control write while the clock stays enabled. Writing zero to the control word shuts everything down. Reads of the count register return the remaining count. Reads of the control word return the two stored enable bits.

Top module: `sysTimer`

## Requirements
- R1: After reset the interrupt output is low, the control word (offset 0x40) reads 0 and the count register (offset 0x44) reads 0.
- R2: A write to offset 0x44 while control bit 0 is 1 loads the count, which reads back at once; each later cycle with tickEn high lowers it by one.
- R3: The count holds its value in cycles where tickEn is low and no register is written.
- R4: When a running count reads zero, the pending event is set on the next clock edge, so the interrupt rises one cycle later if bits 0 and 1 are set; the count then stays at zero with no wrap however many ticks follow.
- R5: A write to the count register while control bit 0 is 0 has no effect on the count or the interrupt.
- R6: The interrupt output is high only while an event is pending and control bits 1 and 0 are both 1; an event that completes with bit 1 at 0 is held and drives the output as soon as bit 1 is set.
- R7: A control write with bits 4 and 0 set clears the pending event; bit 1 of the same write sets the new interrupt enable, so the value 0x11 clears and masks in one write while the clock stays enabled.
- R8: A control write with bit 0 equal to 0 clears both enables and the pending event and halts the countdown; a later re-enable does not resume the count until the count register is written again.
- R9: The control word reads back bit 0 (clock enable) and bit 1 (interrupt enable); bit 4 and all other bits read 0.
- R10: A count write while the countdown runs restarts it from the new value; a count write of zero completes on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-step qualifier, one decrement per high cycle |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset for reads and writes |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irqOut | output | 1 | Timer interrupt, level |

## Verification
The checker checks several rules on every cycle. The count steps by exactly one on a qualified tick and holds otherwise. A running zero count always produces a pending event. Count writes without the clock enable leave the counter untouched. Clear and shutdown writes drop the pending state and the interrupt on the following edge. The bench scenarios cover what needs ordered sequences: the one-cycle lag from a zero count to the interrupt, a masked event surfacing later, a restart mid-count, the zero load, and a shutdown followed by a re-enable that must not resume counting.

// File: rtl/sysTimerPkg.sv
package sysTimerPkg;
  // strobes from the control side to the counting datapath
  typedef struct packed {
    logic load;     // take busWdata as the new count and start
    logic stop;     // halt the countdown
    logic advance;  // a qualified tick this cycle
  } tmrStrobe_t;

  // stored control state
  typedef struct packed {
    logic clkEn;
    logic irqEn;
    logic pending;
  } tmrCfg_t;
endpackage

// File: rtl/sysTimerDp.sv
module sysTimerDp
  import sysTimerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] countQ;
  logic             runQ;

  assign expire  = runQ && (countQ == '0);
  assign count   = countQ;
  assign running = runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      runQ   <= 1'b0;
    end else if (strobe.stop) begin
      runQ <= 1'b0;
    end else if (strobe.load) begin
      countQ <= loadVal;
      runQ   <= 1'b1;
    end else if (expire) begin
      runQ <= 1'b0;
    end else if (strobe.advance && runQ) begin
      countQ <= countQ - 1'b1;
    end
  end
endmodule

// File: rtl/sysTimerCtrl.sv
module sysTimerCtrl
  import sysTimerPkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              CNT_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output tmrStrobe_t        strobe,
  output tmrCfg_t           cfg,
  output logic [DATA_W-1:0] busRdata
);
  localparam int EN_BIT  = 0;
  localparam int IE_BIT  = 1;
  localparam int CLR_BIT = 4;

  tmrCfg_t cfgQ;
  logic    ctrlHit;
  logic    valHit;
  logic    wrEn;
  wire     unusedWdata = &{1'b0, busWdata};

  assign ctrlHit = busWr && (busAddr == CTRL_OFS);
  assign valHit  = busWr && (busAddr == VAL_OFS);
  assign wrEn    = busWdata[EN_BIT];

  assign strobe.load    = valHit && cfgQ.clkEn;
  assign strobe.stop    = ctrlHit && !wrEn;
  assign strobe.advance = tickEn && cfgQ.clkEn;
  assign cfg            = cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctrlHit) begin
      cfgQ.clkEn <= wrEn;
      cfgQ.irqEn <= wrEn && busWdata[IE_BIT];
      if (!wrEn)                 cfgQ.pending <= 1'b0;
      else if (busWdata[CLR_BIT]) cfgQ.pending <= expire;
      else                       cfgQ.pending <= cfgQ.pending || expire;
    end else begin
      cfgQ.pending <= cfgQ.pending || expire;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_OFS) begin
      busRdata[EN_BIT] = cfgQ.clkEn;
      busRdata[IE_BIT] = cfgQ.irqEn;
    end else if (busAddr == VAL_OFS) begin
      busRdata[CNT_W-1:0] = count;
    end
  end
endmodule

// File: rtl/sysTimer.sv
module sysTimer
  import sysTimerPkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = DATA_W,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmrStrobe_t       strobe;
  tmrCfg_t          cfg;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             expire;

  sysTimerCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .count(count),
    .expire(expire), .strobe(strobe), .cfg(cfg), .busRdata(busRdata)
  );

  sysTimerDp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadVal(busWdata[CNT_W-1:0]), .count(count),
    .running(running), .expire(expire)
  );

  assign irqOut = cfg.pending && cfg.irqEn && cfg.clkEn;
endmodule

// File: rtl/sysTimerChk.sv
module sysTimerChk #(
  parameter int                ADDR_W   = 8,
  parameter int                CNT_W    = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input logic [CNT_W-1:0]  count,
  input logic              running,
  input logic              clkEn,
  input logic              irqEn,
  input logic              pending
);
  logic ctrlWr;
  logic valWr;
  assign ctrlWr = busWr && (busAddr == CTRL_OFS);
  assign valWr  = busWr && (busAddr == VAL_OFS);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && count != '0 && tickEn && clkEn && !busWr) |=> (count == $past(count) - 1'b1));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busWr) |=> $stable(count));

  // R4
  zero_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && count == '0 && !busWr) |=> (pending && !running));

  // R5
  gated_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valWr && !clkEn) |=> ($stable(count) && !running));

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqEn && clkEn && pending));

  // R7
  clear_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[0] && busWdata[4] && !(running && count == '0)) |=> !pending);

  // R8
  shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !busWdata[0]) |=> (!irqOut && !running && !clkEn && !irqEn));
endmodule

bind sysTimer sysTimerChk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
  .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .irqOut(irqOut),
  .count(count), .running(running), .clkEn(cfg.clkEn),
  .irqEn(cfg.irqEn), .pending(cfg.pending)
);

// File: tb/sim_sysTimer.sv
module sim_sysTimer;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] VAL  = 8'h44;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  expItem_t    q[$];
  expItem_t    cur;
  logic [31:0] actual;
  int          compared = 0;
  int          mismatched = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sysTimer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // monitor: compares queued expectations a little after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      cur    = q.pop_front();
      actual = cur.isIrq ? {31'b0, irqOut} : busRdata;
      compared++;
      if (actual !== cur.exp) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", cur.req, actual, cur.exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [31:0] e, input string r);
    busAddr = a;
    q.push_back('{isIrq: 1'b0, exp: e, req: r});
    @(negedge clk);
  endtask

  task automatic expectIrq(input logic e, input string r);
    q.push_back('{isIrq: 1'b1, exp: {31'b0, e}, req: r});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectIrq(1'b0, "R1 irq after reset");
    expectRd(CTRL, 32'h0, "R1 control after reset");
    expectRd(VAL, 32'h0, "R1 count after reset");

    // R5 count write without clock enable is ignored
    wrReg(VAL, 32'd5);
    expectIrq(1'b0, "R5 irq after gated write");
    expectRd(VAL, 32'h0, "R5 count after gated write");

    // R9 readback of enables
    wrReg(CTRL, 32'hFFFF_FFE3);
    expectRd(CTRL, 32'h3, "R9 control readback");

    // R2 load and R3 hold
    wrReg(VAL, 32'd5);
    expectRd(VAL, 32'd5, "R2 count after load");
    repeat (3) @(negedge clk);
    expectRd(VAL, 32'd5, "R3 count holds without ticks");
    tick(2);
    expectRd(VAL, 32'd3, "R2 count after two ticks");

    // R4 zero detect timing and no wrap
    tick(3);
    expectIrq(1'b0, "R4 irq on the cycle count hits zero");
    expectRd(VAL, 32'd0, "R4 count at zero");
    expectIrq(1'b1, "R4 irq one cycle after zero");
    tick(3);
    expectRd(VAL, 32'd0, "R4 count stays at zero");

    // R7 clear and mask in one write
    wrReg(CTRL, 32'h11);
    expectIrq(1'b0, "R7 irq after clear-and-mask");
    expectRd(CTRL, 32'h1, "R9 clear bit reads zero");

    // R6 masked event stays pending
    wrReg(VAL, 32'd2);
    tick(2);
    @(negedge clk);
    expectIrq(1'b0, "R6 irq masked while pending");
    @(negedge clk);
    wrReg(CTRL, 32'h3);
    expectIrq(1'b1, "R6 pending shows once unmasked");
    @(negedge clk);

    // R7 clear keeping interrupt enabled
    wrReg(CTRL, 32'h13);
    expectIrq(1'b0, "R7 irq after clear with enable kept");
    expectRd(CTRL, 32'h3, "R7 enable kept by clear write");

    // R10 restart while running and zero load
    wrReg(VAL, 32'd10);
    tick(3);
    expectRd(VAL, 32'd7, "R10 count before restart");
    wrReg(VAL, 32'd4);
    expectRd(VAL, 32'd4, "R10 count after restart");
    tick(1);
    expectRd(VAL, 32'd3, "R10 count after restart tick");
    wrReg(VAL, 32'd0);
    expectIrq(1'b0, "R10 irq right after zero load");
    @(negedge clk);
    expectIrq(1'b1, "R10 zero load completes next edge");
    @(negedge clk);

    // R8 shutdown clears pending and halts the count
    wrReg(VAL, 32'd6);
    tick(2);
    expectRd(VAL, 32'd4, "R8 count before shutdown");
    wrReg(CTRL, 32'h0);
    expectIrq(1'b0, "R8 irq after shutdown");
    expectRd(CTRL, 32'h0, "R8 control after shutdown");
    tick(3);
    expectRd(VAL, 32'd4, "R8 count frozen while disabled");
    wrReg(CTRL, 32'h3);
    tick(5);
    expectRd(VAL, 32'd4, "R8 count not resumed by re-enable");
    expectIrq(1'b0, "R8 pending gone after re-enable");

    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule